// File: doc/BRIEF.md
# Two-Slot Decode Group Allocator

This block sits between an instruction queue and a front end with two decoders. Each cycle the queue offers its two oldest descriptors. Each descriptor is already marked with three things: its length in bytes, how many prefix and escape bytes it carries, and whether it is a branch. The allocator decides how many of the offered descriptors the decoders take in this cycle, from zero to two. The oldest one always goes to slot 0. The next one goes to slot 1, but only when every pairing rule allows it. The queue removes exactly `take_cnt` entries from its head.

The pairing rules are:
- the combined length of both descriptors must fit a per-cycle fetch budget;
- a long descriptor must decode alone;
- a descriptor heavy with prefix or escape bytes must decode alone;
- no two branches may go in the same cycle.

A heavy descriptor also costs a fixed number of extra cycles. During those cycles `rdy` is low, `stall` is high and nothing new is taken. A one-cycle `pen_done` marks the last penalty cycle, when the heavy descriptor completes. A synchronous `flush` cancels the decision of the current cycle and clears any penalty that is in progress.

Top module: `dg_alloc`

## Requirements
- R1: Two descriptors are taken in one cycle only if their lengths add up to at most 16 bytes.
- R2: A descriptor longer than 8 bytes is never placed in slot 1. When one is at the head, it is taken alone on slot 0.
- R3: A descriptor with more than 3 prefix/escape bytes (heavy) is never placed in slot 1. When one is at the head, it is taken alone on slot 0.
- R4: In the 3 cycles after a heavy descriptor is taken, `rdy` is low, `stall` is high and `take_cnt` is 0. In the cycle after those 3, `rdy` is high again.
- R5: `pen_done` is high in exactly the third penalty cycle and in no other cycle.
- R6: At most one branch descriptor is taken per cycle.
- R7: Descriptors are taken in order. `s1_vld` implies `s0_vld`, and nothing is taken while `in_vld0` is low, whatever entry 1 holds.
- R8: When `flush` is high, `take_cnt` is 0 in that cycle. In the following cycle `stall` is low and `rdy` is high.
- R9: After reset, `rdy` is 1, `stall` is 0 and `pen_done` is 0.
- R10: When `rdy` is high, both entries are valid and none of the rules in R1, R2, R3 and R6 forbids the pair, both descriptors are taken (`take_cnt` is 2).
- R11: `take_cnt` always equals `s0_vld + s1_vld`. Slot 0 holds the head entry and slot 1 holds the entry behind it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Cancel this cycle's decision and any penalty in progress |
| in_vld0 | input | 1 | Head descriptor present |
| in_len0 | input | 4 | Head descriptor length in bytes (1 to 15) |
| in_pfx0 | input | 3 | Head descriptor prefix/escape byte count |
| in_br0 | input | 1 | Head descriptor is a branch |
| in_vld1 | input | 1 | Second descriptor present |
| in_len1 | input | 4 | Second descriptor length in bytes (1 to 15) |
| in_pfx1 | input | 3 | Second descriptor prefix/escape byte count |
| in_br1 | input | 1 | Second descriptor is a branch |
| rdy | output | 1 | Allocator can take descriptors this cycle |
| take_cnt | output | 2 | Number of head entries taken this cycle |
| s0_vld | output | 1 | Slot 0 receives the head descriptor |
| s1_vld | output | 1 | Slot 1 receives the second descriptor |
| stall | output | 1 | A penalty cycle is being served |
| pen_done | output | 1 | Last penalty cycle: the heavy descriptor completes |

## Verification
The assertions assume that the descriptor inputs are known values in every cycle. They also assume that a length is never zero, since a zero-length descriptor has no meaning in the fetch budget. They do not assume that the queue holds its entries stable while the allocator stalls, so the bench changes the offered descriptors freely during penalty cycles. The random stimulus keeps lengths between 1 and 15, spreads prefix counts over the whole 3-bit range so that heavy descriptors appear often, and raises `flush` rarely, including inside penalty windows.

// File: rtl/dg_pkg.sv
package dg_pkg;
  parameter int unsigned DG_LEN_W = 4;
  parameter int unsigned DG_PFX_W = 3;

  function automatic logic sum_fits(input logic [DG_LEN_W-1:0] a,
                                    input logic [DG_LEN_W-1:0] b,
                                    input logic [DG_LEN_W:0]   budget);
    logic [DG_LEN_W:0] total;
    total = {1'b0, a} + {1'b0, b};
    return total <= budget;
  endfunction

  function automatic logic is_long(input logic [DG_LEN_W-1:0] len,
                                   input logic [DG_LEN_W-1:0] split);
    return len > split;
  endfunction

  function automatic logic is_heavy(input logic [DG_PFX_W-1:0] pfx,
                                    input logic [DG_PFX_W-1:0] limit);
    return pfx > limit;
  endfunction
endpackage

// File: rtl/dg_pair_rules.sv
module dg_pair_rules
  import dg_pkg::*;
#(
  parameter int unsigned FETCH_BYTES = 16,
  parameter int unsigned SPLIT_LEN   = 8,
  parameter int unsigned PFX_LIMIT   = 3
) (
  input  logic [DG_LEN_W-1:0] len0,
  input  logic [DG_PFX_W-1:0] pfx0,
  input  logic                br0,
  input  logic [DG_LEN_W-1:0] len1,
  input  logic [DG_PFX_W-1:0] pfx1,
  input  logic                br1,
  output logic                head_heavy,
  output logic                pair_ok
);
  localparam logic [DG_LEN_W:0]   BUDGET = FETCH_BYTES[DG_LEN_W:0];
  localparam logic [DG_LEN_W-1:0] SPLIT  = SPLIT_LEN[DG_LEN_W-1:0];
  localparam logic [DG_PFX_W-1:0] PLIM   = PFX_LIMIT[DG_PFX_W-1:0];

  // Named rule events, visible to the assertions in the top
  logic budget_ok;
  logic long_any;
  logic heavy_any;
  logic two_branches;

  always_comb begin
    budget_ok    = sum_fits(len0, len1, BUDGET);
    long_any     = is_long(len0, SPLIT) | is_long(len1, SPLIT);
    heavy_any    = is_heavy(pfx0, PLIM) | is_heavy(pfx1, PLIM);
    two_branches = br0 & br1;
    head_heavy   = is_heavy(pfx0, PLIM);
    pair_ok      = budget_ok & ~long_any & ~heavy_any & ~two_branches;
  end
endmodule

// File: rtl/dg_penalty.sv
module dg_penalty #(
  parameter int unsigned PEN_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flush,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int unsigned CW = $clog2(PEN_CYC + 1);
  localparam logic [CW-1:0] LOAD = PEN_CYC[CW-1:0];
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt <= '0;
    else if (flush)    cnt <= '0;
    else if (start)    cnt <= LOAD;
    else if (cnt != 0) cnt <= cnt - ONE;
  end

  assign busy = (cnt != 0);
  assign last = (cnt == ONE) & ~flush;

  // A new penalty never starts while one is running
  assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
  // A flush empties the counter on the next edge
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !busy);
endmodule

// File: rtl/dg_alloc.sv
module dg_alloc
  import dg_pkg::*;
#(
  parameter int unsigned FETCH_BYTES = 16,
  parameter int unsigned SPLIT_LEN   = 8,
  parameter int unsigned PFX_LIMIT   = 3,
  parameter int unsigned PEN_CYC     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                flush,
  input  logic                in_vld0,
  input  logic [DG_LEN_W-1:0] in_len0,
  input  logic [DG_PFX_W-1:0] in_pfx0,
  input  logic                in_br0,
  input  logic                in_vld1,
  input  logic [DG_LEN_W-1:0] in_len1,
  input  logic [DG_PFX_W-1:0] in_pfx1,
  input  logic                in_br1,
  output logic                rdy,
  output logic [1:0]          take_cnt,
  output logic                s0_vld,
  output logic                s1_vld,
  output logic                stall,
  output logic                pen_done
);
  logic head_heavy;
  logic pair_ok;
  logic pen_busy;
  logic pen_last;
  logic pen_start;

  dg_pair_rules #(
    .FETCH_BYTES(FETCH_BYTES),
    .SPLIT_LEN  (SPLIT_LEN),
    .PFX_LIMIT  (PFX_LIMIT)
  ) u_rules (
    .len0      (in_len0),
    .pfx0      (in_pfx0),
    .br0       (in_br0),
    .len1      (in_len1),
    .pfx1      (in_pfx1),
    .br1       (in_br1),
    .head_heavy(head_heavy),
    .pair_ok   (pair_ok)
  );

  dg_penalty #(.PEN_CYC(PEN_CYC)) u_pen (
    .clk  (clk),
    .rst_n(rst_n),
    .flush(flush),
    .start(pen_start),
    .busy (pen_busy),
    .last (pen_last)
  );

  always_comb begin
    rdy       = ~pen_busy;
    s0_vld    = in_vld0 & ~pen_busy & ~flush;
    s1_vld    = s0_vld & in_vld1 & pair_ok;
    pen_start = s0_vld & head_heavy;
    take_cnt  = {1'b0, s0_vld} + {1'b0, s1_vld};
    stall     = pen_busy;
    pen_done  = pen_last;
  end

  localparam int unsigned PAIR_SUM_MAX = FETCH_BYTES;

  assert_budget_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (32'(in_len0) + 32'(in_len1) <= PAIR_SUM_MAX));
  assert_long_alone_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (32'(in_len0) <= SPLIT_LEN && 32'(in_len1) <= SPLIT_LEN));
  assert_heavy_alone_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (32'(in_pfx0) <= PFX_LIMIT && 32'(in_pfx1) <= PFX_LIMIT));
  assert_heavy_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (s0_vld && 32'(in_pfx0) > PFX_LIMIT) |=> (stall && !rdy && take_cnt == 2'd0));
  assert_done_in_penalty_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pen_done |-> stall);
  assert_one_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> !(in_br0 && in_br1));
  assert_in_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_vld |-> s0_vld) and (s0_vld |-> in_vld0));
  assert_flush_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> take_cnt == 2'd0);
  assert_count_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({s0_vld, s1_vld}) == 32'(take_cnt));
endmodule

// File: tb/dg_alloc_tb.sv
`timescale 1ns/1ps
module dg_alloc_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       flush = 1'b0;
  logic       in_vld0 = 1'b0, in_vld1 = 1'b0;
  logic [3:0] in_len0 = 4'd1, in_len1 = 4'd1;
  logic [2:0] in_pfx0 = 3'd0, in_pfx1 = 3'd0;
  logic       in_br0 = 1'b0, in_br1 = 1'b0;
  logic       rdy, s0_vld, s1_vld, stall, pen_done;
  logic [1:0] take_cnt;

  int checks = 0;
  int errors = 0;
  int pen_left = 0;   // model: penalty cycles still to serve
  bit done = 0;

  always #2.5 clk = ~clk;

  dg_alloc u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .in_vld0(in_vld0), .in_len0(in_len0), .in_pfx0(in_pfx0), .in_br0(in_br0),
    .in_vld1(in_vld1), .in_len1(in_len1), .in_pfx1(in_pfx1), .in_br1(in_br1),
    .rdy(rdy), .take_cnt(take_cnt), .s0_vld(s0_vld), .s1_vld(s1_vld),
    .stall(stall), .pen_done(pen_done)
  );

  // Apply one cycle of stimulus, compare against the model, advance the model
  task automatic step(input bit v0, input int l0, input int p0, input bit b0,
                      input bit v1, input int l1, input int p1, input bit b1,
                      input bit fl, input string tag);
    int  e_take;
    bit  e_s0, e_s1, e_rdy, e_stall, e_done, ok2;
    @(negedge clk);
    in_vld0 = v0; in_len0 = 4'(l0); in_pfx0 = 3'(p0); in_br0 = b0;
    in_vld1 = v1; in_len1 = 4'(l1); in_pfx1 = 3'(p1); in_br1 = b1;
    flush = fl;
    #1;
    e_rdy   = (pen_left == 0);
    e_stall = (pen_left != 0);
    e_done  = (pen_left == 1) && !fl;
    e_s0    = v0 && e_rdy && !fl;
    ok2     = (l0 + l1 <= 16) && (l0 <= 8) && (l1 <= 8) &&
              (p0 <= 3) && (p1 <= 3) && !(b0 && b1);
    e_s1    = e_s0 && v1 && ok2;
    e_take  = int'(e_s0) + int'(e_s1);
    checks++;
    if (rdy !== e_rdy || stall !== e_stall || pen_done !== e_done ||
        s0_vld !== e_s0 || s1_vld !== e_s1 || int'(take_cnt) != e_take) begin
      errors++;
      $display("FAIL %s: got rdy=%0b stall=%0b done=%0b s0=%0b s1=%0b take=%0d exp rdy=%0b stall=%0b done=%0b s0=%0b s1=%0b take=%0d",
               tag, rdy, stall, pen_done, s0_vld, s1_vld, take_cnt,
               e_rdy, e_stall, e_done, e_s0, e_s1, e_take);
    end
    if (fl)                   pen_left = 0;
    else if (e_s0 && p0 > 3)  pen_left = 3;
    else if (pen_left > 0)    pen_left--;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    checks++;
    if (rdy !== 1'b1 || stall !== 1'b0 || pen_done !== 1'b0) begin
      errors++;
      $display("FAIL R9: got rdy=%0b stall=%0b done=%0b exp 1 0 0", rdy, stall, pen_done);
    end
    rst_n = 1'b1;
    step(0,4,0,0, 1,4,0,0, 0, "R7 head empty, entry1 ignored");
    step(1,4,1,0, 1,5,2,0, 0, "R10 legal pair");
    step(1,8,0,0, 1,8,0,0, 0, "R1 exact budget 16");
    step(1,7,0,0, 1,8,0,1, 0, "R10 one branch");
    step(1,9,0,0, 1,2,0,0, 0, "R2 long head alone");
    step(1,3,0,0, 1,9,0,0, 0, "R2 long second not paired");
    step(1,3,0,1, 1,3,0,1, 0, "R6 two branches");
    step(1,3,0,0, 1,3,4,0, 0, "R3 heavy second not paired");
    step(1,3,4,0, 1,3,0,0, 0, "R3 heavy head alone");
    step(1,2,0,0, 1,2,0,0, 0, "R4 penalty 1");
    step(1,2,0,0, 1,2,0,0, 0, "R4 penalty 2");
    step(1,2,0,0, 1,2,0,0, 0, "R5 penalty 3 done");
    step(1,2,0,0, 1,2,0,0, 0, "R4 ready again");
    step(1,5,7,0, 0,1,0,0, 0, "R3 heavy start");
    step(1,2,0,0, 1,2,0,0, 1, "R8 flush in penalty");
    step(1,2,0,0, 1,2,0,0, 0, "R8 after flush");
    step(1,2,0,0, 1,2,0,0, 1, "R8 flush drops take");
    step(1,15,0,0, 1,15,0,0, 0, "R2 max length");
    for (int i = 0; i < 3000; i++) begin
      step($urandom_range(0,7) != 0, $urandom_range(1,15), $urandom_range(0,7), $urandom_range(0,3) == 0,
           $urandom_range(0,7) != 0, $urandom_range(1,15), $urandom_range(0,7), $urandom_range(0,3) == 0,
           $urandom_range(0,15) == 0, "R1 R2 R3 R4 R5 R6 R10 R11 random");
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule